// File: doc/BRIEF.md
# Data-Dependent Vector Length Truncation Unit

This unit takes the per-element results of a vector operation, one element at a time starting at element 0, and works out a new vector length. The new length covers only the unbroken run of leading elements that pass a selectable test. The unit also produces two write-enable masks for the register-file stage that follows: one for destination values and one for condition fields. The arithmetic that makes the element results is done elsewhere and is outside this unit.

An operation begins with a one-cycle `start` pulse. The pulse carries the current vector length, a 5-bit mode field and the condition-write flag `rc_in`. The element results then arrive on a valid/ready stream. `in_ready` is high only while the unit is scanning. An element is consumed on each clock edge where `in_valid` and `in_ready` are both high. Holding `in_valid` low stalls the scan and changes no state, so the producer can pause between elements as long as it needs.

The unit always consumes exactly as many elements as the vector length, including elements after the first failure. This drains the producer's stream cleanly. When the scan finishes, the results are registered and announced with a one-cycle `done` pulse. The registered results then hold until the next operation completes.

Top module: `ffvl_trunc`

## Requirements
- R1: After reset, `in_ready`, `done`, `vl_out`, `dst_we` and `cr_we` are all zero.
- R2: When `mode_in[4:3]` is anything other than 2'b01, no truncation is done. `vl_out` equals the vector length. `dst_we` has bits 0..vl-1 set. `cr_we` equals `dst_we` when `rc_in`=1 and is zero when `rc_in`=0.
- R3: With `mode_in[4:3]`=2'b01 and `rc_in`=1, each element tests bit `in_cond[3-mode_in[1:0]]`. The field layout is `in_cond[3]`=lt, [2]=gt, [1]=eq, [0]=so, so select 0 tests lt and select 3 tests so. That bit is XORed with `mode_in[2]`, and the element passes if the result is 1. `vl_out` is the index of the first failing element.
- R4: With `mode_in[4:3]`=2'b01 and `rc_in`=0, an element passes when (`in_zero`=0) XOR `mode_in[2]` is 1. `mode_in[1]`=1 makes `vl_out` equal the first failing index plus one. `mode_in[1]`=0 makes `vl_out` equal that index.
- R5: In the truncating mode, if no element fails, `vl_out` equals the vector length unchanged.
- R6: `dst_we` has bit i set exactly when i < `vl_out`. The exception is the condition-only variant (`mode_in[4:3]`=2'b01, `rc_in`=0, `mode_in[0]`=1), where `dst_we` is all zero.
- R7: In the truncating mode, `cr_we` depends on the flags. With `rc_in`=1 it covers elements 0 through the first failing element inclusive, or 0..vl-1 if none fails. In the condition-only variant it covers elements below `vl_out`. With `rc_in`=0 and `mode_in[0]`=0 it is all zero.
- R8: `in_ready` is high only during the scan, and exactly min(`vl_in`, MAX_VL) elements are accepted. A vector length above MAX_VL is clamped to MAX_VL. Holding `in_valid` low leaves the scan position unchanged.
- R9: `done` is a single-cycle pulse. It is high in the second cycle after the edge that accepts the last element, or after the `start` edge when the vector length is zero.
- R10: A `start` pulse given while an operation is in progress is ignored.
- R11: `vl_out`, `dst_we` and `cr_we` keep their values from one `done` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts an operation when the unit is idle |
| vl_in | input | VLW (7) | Current vector length |
| mode_in | input | 5 | [4:3] mode select, [2] invert, [1:0] bit select or {include, condition-only} |
| rc_in | input | 1 | Condition-field write flag |
| in_valid | input | 1 | Element result valid |
| in_ready | output | 1 | Unit accepts an element |
| in_cond | input | 4 | Element condition field: lt, gt, eq, so |
| in_zero | input | 1 | Element arithmetic result equals zero |
| done | output | 1 | One-cycle completion pulse |
| vl_out | output | VLW (7) | Truncated vector length |
| dst_we | output | MAX_VL (64) | Destination write-enable mask |
| cr_we | output | MAX_VL (64) | Condition-field write-enable mask |

## Verification
Several patterns are used to separate the behaviours:
- A failure placed in the middle of a run separates the exclusive and inclusive length rules and shows the condition-mask extension. A failure at element 0 and a run with no failure pin down the two ends of the length range.
- Putting only one condition bit low in the failing element tells the four bit selections apart and shows which way the invert bit acts.
- Vector lengths of zero, exactly MAX_VL and above MAX_VL test the clamp and the empty path.
- Random gaps in `in_valid`, with stray `start` pulses during a scan, show that a stall or a restart attempt does not move the scan position.
- Random operations whose condition bits are mostly 1, so failures come late, cover everything in between.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;

  localparam logic [1:0] SEL_TRUNCATE = 2'b01;

  typedef struct packed {
    logic       ff;         // truncating mode selected
    logic       inv;        // invert test sense
    logic [1:0] crsel;      // condition bit select (rc=1)
    logic       incl;       // include failing element (rc=0)
    logic       cond_only;  // suppress destination writes (rc=0)
    logic       rc;         // condition-field write flag
  } ffcfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } scan_st_e;

endpackage

// File: rtl/ffvl_decode.sv
module ffvl_decode
  import ffvl_pkg::*;
(
  input  logic [4:0] mode_in,
  input  logic       rc_in,
  output ffcfg_t     cfg
);

  logic is_trunc;

  assign is_trunc = (mode_in[4:3] == SEL_TRUNCATE);

  always_comb begin
    cfg           = '0;
    cfg.ff        = is_trunc;
    cfg.rc        = rc_in;
    cfg.inv       = is_trunc & mode_in[2];
    cfg.crsel     = rc_in ? mode_in[1:0] : 2'b00;
    cfg.incl      = is_trunc & ~rc_in & mode_in[1];
    cfg.cond_only = is_trunc & ~rc_in & mode_in[0];
  end

endmodule

// File: rtl/ffvl_scan.sv
module ffvl_scan
  import ffvl_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int VLW    = $clog2(MAX_VL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl_in,
  input  ffcfg_t         cfg_in,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [3:0]     in_cond,
  input  logic           in_zero,
  output logic           fin,
  output ffcfg_t         cfg_q,
  output logic [VLW-1:0] vl_q,
  output logic           fail_seen_q,
  output logic [VLW-1:0] fail_idx_q
);

  localparam logic [VLW-1:0] VL_CAP = VLW'(MAX_VL);

  scan_st_e       state_q;
  logic [VLW-1:0] idx_q;
  logic [VLW-1:0] vl_clamped;
  logic           take;
  logic           test_bit;
  logic           elem_fails;

  assign vl_clamped = (vl_in > VL_CAP) ? VL_CAP : vl_in;
  assign in_ready   = (state_q == ST_SCAN);
  assign take       = in_valid & in_ready;
  assign fin        = (state_q == ST_FIN);

  always_comb begin
    if (cfg_q.rc) begin
      case (cfg_q.crsel)
        2'd0:    test_bit = in_cond[3];
        2'd1:    test_bit = in_cond[2];
        2'd2:    test_bit = in_cond[1];
        default: test_bit = in_cond[0];
      endcase
    end else begin
      test_bit = ~in_zero;
    end
  end

  assign elem_fails = cfg_q.ff & ~(test_bit ^ cfg_q.inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      vl_q        <= '0;
      cfg_q       <= '0;
      fail_seen_q <= 1'b0;
      fail_idx_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            vl_q        <= vl_clamped;
            cfg_q       <= cfg_in;
            idx_q       <= '0;
            fail_seen_q <= 1'b0;
            fail_idx_q  <= '0;
            state_q     <= (vl_clamped == '0) ? ST_FIN : ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (take) begin
            if (elem_fails && !fail_seen_q) begin
              fail_seen_q <= 1'b1;
              fail_idx_q  <= idx_q;
            end
            idx_q <= idx_q + 1'b1;
            if (idx_q == vl_q - 1'b1) state_q <= ST_FIN;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_accept_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (idx_q < vl_q));

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && !in_valid) |=> $stable(idx_q));

  p_fin_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (state_q == ST_IDLE));

  p_fail_within_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fail_seen_q |-> (fail_idx_q < vl_q));

  p_busy_ignores_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && start) |=> $stable(vl_q));

endmodule

// File: rtl/ffvl_mask.sv
module ffvl_mask #(
  parameter int MAX_VL = 64,
  parameter int VLW    = $clog2(MAX_VL + 1)
) (
  input  logic [VLW-1:0]    len,
  output logic [MAX_VL-1:0] mask
);

  for (genvar g = 0; g < MAX_VL; g++) begin : g_bit
    assign mask[g] = (len > VLW'(g));
  end

endmodule

// File: rtl/ffvl_result.sv
module ffvl_result #(
  parameter int MAX_VL = 64,
  parameter int VLW    = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin,
  input  logic              cfg_ff,
  input  logic              cfg_rc,
  input  logic              cfg_incl,
  input  logic              cfg_cond_only,
  input  logic [VLW-1:0]    vl_q,
  input  logic              fail_seen_q,
  input  logic [VLW-1:0]    fail_idx_q,
  output logic              done,
  output logic [VLW-1:0]    vl_out,
  output logic [MAX_VL-1:0] dst_we,
  output logic [MAX_VL-1:0] cr_we
);

  logic              truncated;
  logic [VLW-1:0]    new_vl_c;
  logic [VLW-1:0]    cr_len_c;
  logic [MAX_VL-1:0] dst_mask_c;
  logic [MAX_VL-1:0] cr_mask_c;

  assign truncated = cfg_ff & fail_seen_q;
  assign new_vl_c  = truncated ? (fail_idx_q + VLW'(cfg_incl)) : vl_q;

  always_comb begin
    if (cfg_rc)             cr_len_c = truncated ? (fail_idx_q + 1'b1) : vl_q;
    else if (cfg_cond_only) cr_len_c = new_vl_c;
    else                    cr_len_c = '0;
  end

  ffvl_mask #(.MAX_VL(MAX_VL), .VLW(VLW)) u_dst_mask (
    .len  (new_vl_c),
    .mask (dst_mask_c)
  );

  ffvl_mask #(.MAX_VL(MAX_VL), .VLW(VLW)) u_cr_mask (
    .len  (cr_len_c),
    .mask (cr_mask_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      vl_out <= '0;
      dst_we <= '0;
      cr_we  <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        vl_out <= new_vl_c;
        dst_we <= cfg_cond_only ? '0 : dst_mask_c;
        cr_we  <= cr_mask_c;
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_vl_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vl_out <= vl_q));

  p_dst_contiguous_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((dst_we & (dst_we + 1'b1)) == '0));

  p_dst_within_cr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_rc) |-> ((dst_we & ~cr_we) == '0));

  p_hold_outputs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> ($stable(vl_out) && $stable(dst_we) && $stable(cr_we)));

endmodule

// File: rtl/ffvl_trunc.sv
module ffvl_trunc
  import ffvl_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VLW   = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VLW-1:0]    vl_in,
  input  logic [4:0]        mode_in,
  input  logic              rc_in,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_cond,
  input  logic              in_zero,
  output logic              done,
  output logic [VLW-1:0]    vl_out,
  output logic [MAX_VL-1:0] dst_we,
  output logic [MAX_VL-1:0] cr_we
);

  ffcfg_t         cfg_dec;
  ffcfg_t         cfg_q;
  logic           fin;
  logic [VLW-1:0] vl_q;
  logic           fail_seen_q;
  logic [VLW-1:0] fail_idx_q;

  ffvl_decode u_decode (
    .mode_in (mode_in),
    .rc_in   (rc_in),
    .cfg     (cfg_dec)
  );

  ffvl_scan #(.MAX_VL(MAX_VL), .VLW(VLW)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .vl_in       (vl_in),
    .cfg_in      (cfg_dec),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_cond     (in_cond),
    .in_zero     (in_zero),
    .fin         (fin),
    .cfg_q       (cfg_q),
    .vl_q        (vl_q),
    .fail_seen_q (fail_seen_q),
    .fail_idx_q  (fail_idx_q)
  );

  ffvl_result #(.MAX_VL(MAX_VL), .VLW(VLW)) u_result (
    .clk           (clk),
    .rst_n         (rst_n),
    .fin           (fin),
    .cfg_ff        (cfg_q.ff),
    .cfg_rc        (cfg_q.rc),
    .cfg_incl      (cfg_q.incl),
    .cfg_cond_only (cfg_q.cond_only),
    .vl_q          (vl_q),
    .fail_seen_q   (fail_seen_q),
    .fail_idx_q    (fail_idx_q),
    .done          (done),
    .vl_out        (vl_out),
    .dst_we        (dst_we),
    .cr_we         (cr_we)
  );

  p_ready_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

endmodule

// File: tb/ffvl_trunc_test.sv
`timescale 1ns/1ps
module ffvl_trunc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vl_in = '0;
  logic [4:0]  mode_in = '0;
  logic        rc_in = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_cond = '0;
  logic        in_zero = 1'b0;
  logic        done;
  logic [6:0]  vl_out;
  logic [63:0] dst_we;
  logic [63:0] cr_we;

  always #2.5 clk = ~clk;

  ffvl_trunc uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .mode_in(mode_in),
    .rc_in(rc_in), .in_valid(in_valid), .in_ready(in_ready), .in_cond(in_cond),
    .in_zero(in_zero), .done(done), .vl_out(vl_out), .dst_we(dst_we), .cr_we(cr_we)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  string cur_tag = "R1";

  logic [3:0] e_cond [64];
  logic       e_zero [64];

  // reference model state
  int          m_phase = 0;
  int          m_cnt   = 0;
  int          m_vl    = 0;
  logic [4:0]  m_mode  = '0;
  logic        m_rc    = 1'b0;
  bit          m_done  = 0;
  int          m_nvl   = 0;
  logic [63:0] m_dst   = '0;
  logic [63:0] m_cr    = '0;
  logic [3:0]  q_cond[$];
  logic        q_zero[$];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic logic [63:0] low_mask(int n);
    if (n >= 64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  task automatic finish_model();
    bit ff;
    bit inv;
    bit cond_only;
    bit raw;
    int fail;
    int crl;
    ff        = (m_mode[4:3] == 2'b01);
    inv       = m_mode[2];
    cond_only = ff && !m_rc && m_mode[0];
    fail      = -1;
    for (int i = 0; i < m_vl; i++) begin
      if (ff) begin
        raw = m_rc ? q_cond[i][3 - int'(m_mode[1:0])] : !q_zero[i];
        if (raw == inv && fail < 0) fail = i;
      end
    end
    if (ff && fail >= 0) m_nvl = fail + ((!m_rc && m_mode[1]) ? 1 : 0);
    else                 m_nvl = m_vl;
    if (m_rc)           crl = (ff && fail >= 0) ? fail + 1 : m_vl;
    else if (cond_only) crl = m_nvl;
    else                crl = 0;
    m_dst = cond_only ? 64'd0 : low_mask(m_nvl);
    m_cr  = low_mask(crl);
  endtask

  task automatic summary_and_end();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // one clock: check ready, advance model across the edge, check outputs
  task automatic tick();
    bit nd;
    chk("R8", "in_ready", 64'(in_ready), 64'(m_phase == 1));
    @(posedge clk);
    cyc++;
    nd = 0;
    if (!rst_n) begin
      m_phase = 0; m_nvl = 0; m_dst = '0; m_cr = '0;
    end else begin
      case (m_phase)
        0: if (start) begin
             m_vl    = (vl_in > 7'd64) ? 64 : int'(vl_in);
             m_mode  = mode_in;
             m_rc    = rc_in;
             m_cnt   = 0;
             q_cond.delete();
             q_zero.delete();
             m_phase = (m_vl == 0) ? 2 : 1;
           end
        1: if (in_valid) begin
             q_cond.push_back(in_cond);
             q_zero.push_back(in_zero);
             m_cnt++;
             if (m_cnt == m_vl) m_phase = 2;
           end
        default: begin
          finish_model();
          nd = 1;
          m_phase = 0;
        end
      endcase
    end
    m_done = nd;
    #1;
    chk("R9", "done", 64'(done), 64'(m_done));
    chk({cur_tag, "/R11"}, "vl_out", 64'(vl_out), 64'(m_nvl));
    chk("R6", "dst_we", dst_we, m_dst);
    chk("R7", "cr_we", cr_we, m_cr);
    if (cyc > 150000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary_and_end();
    end
  endtask

  task automatic fill(logic [3:0] c, logic z);
    for (int i = 0; i < 64; i++) begin
      e_cond[i] = c;
      e_zero[i] = z;
    end
  endtask

  task automatic run_op(string tag, int vl, logic [4:0] mode, logic rc, int gap_pct, bit disturb);
    int eff;
    cur_tag = tag;
    eff = (vl > 64) ? 64 : vl;
    start = 1'b1; vl_in = 7'(vl); mode_in = mode; rc_in = rc;
    tick();
    start = 1'b0;
    for (int i = 0; i < eff; i++) begin
      if ($urandom_range(99) < gap_pct) begin
        in_valid = 1'b0;
        if (disturb) begin
          start = 1'b1; vl_in = 7'd3; mode_in = 5'b00000; rc_in = ~rc;  // R10 stray start
        end
        tick();
        start = 1'b0; vl_in = 7'(vl); mode_in = mode; rc_in = rc;
      end
      in_valid = 1'b1;
      in_cond  = e_cond[i];
      in_zero  = e_zero[i];
      tick();
    end
    in_valid = 1'b0;
    tick();
    tick();
    tick();
  endtask

  initial begin
    fill(4'hF, 1'b0);
    tick();
    tick();
    chk("R1", "reset vl_out", 64'(vl_out), 64'd0);
    chk("R1", "reset dst_we", dst_we, 64'd0);
    chk("R1", "reset cr_we", cr_we, 64'd0);
    chk("R1", "reset done", 64'(done), 64'd0);
    chk("R1", "reset in_ready", 64'(in_ready), 64'd0);
    rst_n = 1'b1;
    tick();

    // R2 normal mode, no condition writes
    fill(4'h0, 1'b1);
    run_op("R2", 10, 5'b00110, 1'b0, 0, 0);
    chk("R2", "normal vl", 64'(vl_out), 64'd10);
    // R2 normal mode with condition writes, full length
    run_op("R2", 64, 5'b10011, 1'b1, 10, 0);
    chk("R2", "normal cr_we", cr_we, '1);

    // R3 eq bit select, element 5 fails
    fill(4'hF, 1'b0);
    e_cond[5] = 4'b1101;
    e_cond[9] = 4'b1101;
    run_op("R3", 12, 5'b01010, 1'b1, 0, 0);
    chk("R3", "eq fail vl", 64'(vl_out), 64'd5);
    chk("R7", "cr includes failing", cr_we, 64'h3F);
    // R3 lt with invert: lt=1 at element 0 fails
    fill(4'b0111, 1'b0);
    e_cond[0] = 4'b1000;
    run_op("R3", 8, 5'b01100, 1'b1, 0, 0);
    chk("R3", "inverted lt vl", 64'(vl_out), 64'd0);
    chk("R7", "cr one element", cr_we, 64'h1);
    // R3 so select: only so bit low at element 3
    fill(4'hF, 1'b0);
    e_cond[2] = 4'b0111;
    e_cond[3] = 4'b1110;
    run_op("R3", 6, 5'b01011, 1'b1, 0, 0);
    chk("R3", "so select vl", 64'(vl_out), 64'd3);

    // R4 zero test, exclusive and inclusive
    fill(4'h0, 1'b0);
    e_zero[7] = 1'b1;
    run_op("R4", 16, 5'b01000, 1'b0, 20, 0);
    chk("R4", "exclusive vl", 64'(vl_out), 64'd7);
    chk("R7", "no cr writes", cr_we, 64'd0);
    run_op("R4", 16, 5'b01010, 1'b0, 0, 0);
    chk("R4", "inclusive vl", 64'(vl_out), 64'd8);
    // R4 inverted: nonzero at element 0 fails, inclusive
    run_op("R4", 16, 5'b01110, 1'b0, 0, 0);
    chk("R4", "inverted inclusive vl", 64'(vl_out), 64'd1);

    // R6/R7 condition-only variant
    run_op("R6", 16, 5'b01011, 1'b0, 0, 0);
    chk("R6", "cond-only dst_we", dst_we, 64'd0);
    chk("R7", "cond-only cr_we", cr_we, 64'hFF);

    // R5 no failure
    fill(4'hF, 1'b0);
    run_op("R5", 20, 5'b01001, 1'b1, 30, 0);
    chk("R5", "no fail vl", 64'(vl_out), 64'd20);

    // R9 zero length
    run_op("R9", 0, 5'b01000, 1'b1, 0, 0);
    chk("R9", "empty vl", 64'(vl_out), 64'd0);

    // R8/R10 clamp above MAX_VL with gaps and stray starts
    fill(4'hF, 1'b0);
    e_cond[60] = 4'b1011;
    run_op("R8", 70, 5'b01001, 1'b1, 40, 1);
    chk("R8", "clamped vl", 64'(vl_out), 64'd60);
    run_op("R10", 30, 5'b00000, 1'b0, 50, 1);
    chk("R10", "stray start ignored", 64'(vl_out), 64'd30);

    // random operations, late failures
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < 64; i++) begin
        e_cond[i] = ($urandom_range(19) == 0) ? 4'($urandom) : 4'hF;
        e_zero[i] = ($urandom_range(15) == 0);
      end
      run_op("R3", int'($urandom_range(66)), 5'($urandom), 1'($urandom), 25, k[0]);
    end

    summary_and_end();
  end

endmodule